// File: doc/BRIEF.md
# DDC Display Identification Target

This block is the per-port target on a display data channel. A video source upstream reads display identification bytes and a small set of content-protection registers through it. SCL and SDA are oversampled on the system clock. The block finds START and STOP conditions and takes the device address from the first byte. It then answers one of two device addresses. Each address opens its own window, and each window keeps its own byte pointer.

A write transfer sets the pointer of the window it addresses. A read then streams bytes from that pointer, most significant bit first. The pointer advances after each byte and wraps at the top of the window.

Bytes come from a private bank through a synchronous read port. One instance serves each connector, so all connectors can be read at the same time. The channel side never writes the bank. For an analog-video connector, a smaller instance is built with a 7-bit pointer.

Top module: `ddc_edid_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0x50 (bytes 0xA0 write, 0xA1 read) is acknowledged, and its reads are fetched with `rd_win_o` = 0.
- R2: An address byte whose upper seven bits equal 0x3A (bytes 0x74 write, 0x75 read) is acknowledged, and its reads are fetched with `rd_win_o` = 1.
- R3: Any other address is not acknowledged. SDA stays released and no read is issued until the next START.
- R4: In a write transfer, the first byte after the address is acknowledged and becomes the pointer of the addressed window.
- R5: Further bytes of a write transfer are not acknowledged, cause the transfer to be abandoned, and leave the pointer unchanged.
- R6: A read returns window bytes starting at the pointer. The pointer advances by one after each transmitted byte and wraps from 2^ADDR_W-1 to 0.
- R7: A NACK from the host after a byte ends the read. SDA stays released for the remaining clocks, and no further read is issued. The pointer then sits just past the last byte sent.
- R8: Each window has its own pointer. Setting or advancing one window's pointer does not move the other.
- R9: A START in any state restarts the address phase. A STOP returns the target to idle with SDA released. A byte cut short by START or STOP does not advance the pointer.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The target only begins pulling SDA low while the synchronised SCL is low.
- R11: The memory read port gives a one-cycle `rd_en_o` pulse together with `rd_win_o` and `rd_addr_o`. `rd_data_i` is taken one cycle later, and each fetch happens while SCL is low.
- R12: After reset, SDA is released and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_en_o | output | 1 | One-cycle read request to the bank |
| rd_win_o | output | 1 | Window of the request: 0 identification data, 1 protection registers |
| rd_addr_o | output | ADDR_W | Byte offset of the request |
| rd_data_i | input | 8 | Bank data, valid the cycle after `rd_en_o` |

## Verification
A corrupted pointer shows up on the bus within one byte, either as a wrong byte value or as a skipped or repeated byte. This is most visible across the wrap and after a NACK or an aborted byte. A wrong protocol state shows up on the next acknowledge slot as an ACK where a NACK belongs, or the reverse, or as stray read requests. A mixed-up window shows up as the wrong `rd_win_o` on the first fetch after the address byte, and as one window's pointer moving when only the other was used.

// File: rtl/ddc_edid_pkg.sv
package ddc_edid_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_WAIT
  } ddc_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_OFS,
    PH_DATA
  } ddc_phase_e;
endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // bus conditions only count while SCL is stable high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/ddc_shifter.sv
module ddc_shifter #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             sda_i,
  input  logic             load_i,
  input  logic [W-1:0]     load_data_i,
  input  logic             shift_i,
  output logic [W-1:0]     rx_o,
  output logic             tx_bit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      tx_q  <= '1;
      cnt_q <= '0;
    end else begin
      if (clr_i)         cnt_q <= '0;
      else if (sample_i) cnt_q <= cnt_q + CNT_W'(1);
      if (sample_i) rx_q <= {rx_q[W-2:0], sda_i};
      if (load_i)       tx_q <= load_data_i;
      else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b1};
    end
  end

  assign rx_o     = rx_q;
  assign tx_bit_o = tx_q[W-1];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_edid_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [6:0]  EDID_DEV = 7'h50,
  parameter logic [6:0]  HDCP_DEV = 7'h3A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] rx_i,
  input  logic              tx_bit_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic              load_o,
  output logic              shift_o,
  output logic [BYTE_W-1:0] load_data_o,
  output logic              pull_o,
  output logic              rd_en_o,
  output logic              rd_win_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  ddc_state_e st_q, st_d;
  ddc_phase_e ph_q, ph_d;
  logic win_q, win_d, rw_q, rw_d;
  logic [ADDR_W-1:0] ofs_q [2];
  logic ofs_we;
  logic [ADDR_W-1:0] ofs_wdata, ofs_cur;
  logic fetch;
  logic [ADDR_W-1:0] fetch_addr;
  logic fetch_win;
  logic rd_en_q, rd_win_q, rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [BYTE_W-1:0] pre_q;
  logic hit_edid, hit_hdcp, byte_done;

  assign hit_edid  = rx_i[7:1] == EDID_DEV;
  assign hit_hdcp  = rx_i[7:1] == HDCP_DEV;
  assign byte_done = cnt_i == LAST_BIT;
  assign ofs_cur   = ofs_q[win_q];

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    win_d      = win_q;
    rw_d       = rw_q;
    clr_o      = 1'b0;
    load_o     = 1'b0;
    shift_o    = 1'b0;
    ofs_we     = 1'b0;
    ofs_wdata  = ofs_cur;
    fetch      = 1'b0;
    fetch_addr = ofs_cur;
    fetch_win  = win_q;
    if (start_i) begin
      st_d  = ST_RX;
      ph_d  = PH_ADDR;
      clr_o = 1'b1;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else if (fall_i) begin
      unique case (st_q)
        ST_RX: if (byte_done) begin
          clr_o = 1'b1;
          unique case (ph_q)
            PH_ADDR: if (hit_edid || hit_hdcp) begin
              st_d  = ST_ACK;
              ph_d  = PH_OFS;
              win_d = hit_hdcp;
              rw_d  = rx_i[0];
              if (rx_i[0]) begin
                fetch      = 1'b1;
                fetch_win  = hit_hdcp;
                fetch_addr = ofs_q[hit_hdcp];
              end
            end else begin
              st_d = ST_WAIT;
            end
            PH_OFS: begin
              st_d      = ST_ACK;
              ph_d      = PH_DATA;
              ofs_we    = 1'b1;
              ofs_wdata = rx_i[ADDR_W-1:0];
            end
            default: st_d = ST_WAIT;
          endcase
        end
        ST_ACK: begin
          clr_o = 1'b1;
          if (rw_q) begin
            st_d   = ST_TX;
            load_o = 1'b1;
          end else begin
            st_d = ST_RX;
          end
        end
        ST_TX: if (byte_done) begin
          st_d       = ST_HACK;
          clr_o      = 1'b1;
          ofs_we     = 1'b1;
          ofs_wdata  = ofs_cur + ADDR_W'(1);
          fetch      = 1'b1;
          fetch_addr = ofs_cur + ADDR_W'(1);
        end else begin
          shift_o = 1'b1;
        end
        ST_HACK: begin
          clr_o = 1'b1;
          if (!rx_i[0]) begin
            st_d   = ST_TX;
            load_o = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_ADDR;
      win_q     <= 1'b0;
      rw_q      <= 1'b0;
      ofs_q[0]  <= '0;
      ofs_q[1]  <= '0;
      rd_en_q   <= 1'b0;
      rd_win_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
      pre_q     <= '0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      win_q     <= win_d;
      rw_q      <= rw_d;
      if (ofs_we) ofs_q[win_q] <= ofs_wdata;
      rd_en_q   <= fetch;
      if (fetch) begin
        rd_win_q  <= fetch_win;
        rd_addr_q <= fetch_addr;
      end
      rd_pend_q <= rd_en_q;
      if (rd_pend_q) pre_q <= rd_data_i;
    end
  end

  assign load_data_o = pre_q;
  assign pull_o      = (st_q == ST_ACK) || ((st_q == ST_TX) && !tx_bit_i);
  assign rd_en_o     = rd_en_q;
  assign rd_win_o    = rd_win_q;
  assign rd_addr_o   = rd_addr_q;
endmodule

// File: rtl/ddc_edid_target.sv
module ddc_edid_target
  import ddc_edid_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  EDID_DEV    = 7'h50,
  parameter logic [6:0]  HDCP_DEV    = 7'h3A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              rd_en_o,
  output logic              rd_win_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic clr, load, shift, tx_bit;
  logic [BYTE_W-1:0] rx_byte, load_data;
  logic [CNT_W-1:0] bit_cnt;

  ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  ddc_shifter #(.W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .clr_i(clr), .sample_i(scl_rise), .sda_i(sda_s),
    .load_i(load), .load_data_i(load_data), .shift_i(shift),
    .rx_o(rx_byte), .tx_bit_o(tx_bit), .cnt_o(bit_cnt)
  );

  ddc_ctrl #(.ADDR_W(ADDR_W), .EDID_DEV(EDID_DEV), .HDCP_DEV(HDCP_DEV)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop), .fall_i(scl_fall),
    .rx_i(rx_byte), .tx_bit_i(tx_bit), .cnt_i(bit_cnt),
    .clr_o(clr), .load_o(load), .shift_o(shift), .load_data_o(load_data),
    .pull_o(sda_pull_o),
    .rd_en_o, .rd_win_o, .rd_addr_o, .rd_data_i
  );
endmodule

// File: rtl/ddc_edid_target_chk.sv
module ddc_edid_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic start_i,
  input logic stop_i,
  input logic sda_pull_i,
  input logic rd_en_i
);
  p_pull_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> !scl_s_i);
  p_start_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_pull_i);
  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_i);
  p_rd_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> !rd_en_i);
  p_rd_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !scl_s_i);
endmodule

bind ddc_edid_target ddc_edid_target_chk u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .scl_s_i(scl_s),
  .start_i(start),
  .stop_i(stop),
  .sda_pull_i(sda_pull_o),
  .rd_en_i(rd_en_o)
);

// File: tb/ddc_edid_target_test.sv
module ddc_edid_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_bus, sda_pull, rd_en, rd_win;
  logic [7:0] rd_addr, mem_q;
  int n_vec = 0, n_bad = 0, rd_count = 0, pull_rises = 0, r10_viol = 0;
  logic prev_pull = 1'b0, last_win = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = host_sda & ~sda_pull;

  ddc_edid_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .rd_en_o(rd_en), .rd_win_o(rd_win),
    .rd_addr_o(rd_addr), .rd_data_i(mem_q)
  );

  function automatic logic [7:0] edid_f(logic [7:0] a);
    return 8'(a * 3 + 7);
  endfunction
  function automatic logic [7:0] hdcp_f(logic [7:0] a);
    return a ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      mem_q    <= rd_win ? hdcp_f(rd_addr) : edid_f(rd_addr);
      rd_count <= rd_count + 1;
      last_win <= rd_win;
    end
    prev_pull <= sda_pull;
    if (sda_pull && !prev_pull) pull_rises <= pull_rises + 1;
    if (sda_pull && !prev_pull && scl) r10_viol <= r10_viol + 1;
  end

  task automatic wait_c(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wait_c(HALF/2);
    scl = 1'b1;      wait_c(HALF);
    host_sda = 1'b0; wait_c(HALF);
    scl = 1'b0;      wait_c(HALF/2);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wait_c(HALF/2);
    scl = 1'b1;      wait_c(HALF);
    host_sda = 1'b1; wait_c(HALF);
  endtask

  task automatic put_bit(logic b);
    host_sda = b; wait_c(HALF/2);
    scl = 1'b1;   wait_c(HALF);
    scl = 1'b0;   wait_c(HALF/2);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; wait_c(HALF/2);
    scl = 1'b1;      wait_c(HALF/2);
    b = sda_bus;     wait_c(HALF/2);
    scl = 1'b0;      wait_c(HALF/2);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    put_bit(~ack);
  endtask

  task automatic t_reset();
    logic ack;
    logic [7:0] v;
    check("R12 sda released", sda_pull, 0);
    check("R12 no read", rd_en, 0);
    bus_start(); send_byte(8'hA1, ack);
    check("R1 read addr ack", ack, 1);
    recv_byte(v, 1'b0);
    check("R12 pointer zero", v, edid_f(8'h00));
    bus_stop();
  endtask

  task automatic t_edid_seq();
    logic ack;
    logic [7:0] v;
    bus_start(); send_byte(8'hA0, ack);
    check("R1 write addr ack", ack, 1);
    send_byte(8'h10, ack);
    check("R4 offset ack", ack, 1);
    bus_start(); send_byte(8'hA1, ack);
    check("R1 read addr ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(v, i != 3);
      check("R6 R11 stream byte", v, edid_f(8'(8'h10 + i)));
    end
    check("R1 window 0", last_win, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b1);
    check("R6 current read", v, edid_f(8'h14));
    recv_byte(v, 1'b0);
    check("R6 current read next", v, edid_f(8'h15));
    bus_stop();
  endtask

  task automatic t_wrap();
    logic ack;
    logic [7:0] v;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'hFE, ack);
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b1); check("R6 byte FE", v, edid_f(8'hFE));
    recv_byte(v, 1'b1); check("R6 byte FF", v, edid_f(8'hFF));
    recv_byte(v, 1'b0); check("R6 wrap to 00", v, edid_f(8'h00));
    bus_stop();
  endtask

  task automatic t_hdcp();
    logic ack;
    logic [7:0] v;
    bus_start(); send_byte(8'h74, ack);
    check("R2 write addr ack", ack, 1);
    send_byte(8'h05, ack);
    bus_start(); send_byte(8'h75, ack);
    check("R2 read addr ack", ack, 1);
    recv_byte(v, 1'b1); check("R2 byte 5", v, hdcp_f(8'h05));
    recv_byte(v, 1'b0); check("R2 byte 6", v, hdcp_f(8'h06));
    check("R2 window 1", last_win, 1);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b0);
    check("R8 edid pointer kept", v, edid_f(8'h01));
    check("R8 window 0 again", last_win, 0);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic ack;
    int rd0, pr0;
    rd0 = rd_count; pr0 = pull_rises;
    bus_start(); send_byte(8'hA2, ack);
    check("R3 no ack", ack, 0);
    send_byte(8'hA1, ack);
    check("R3 ignored until start", ack, 0);
    check("R3 no read", rd_count, rd0);
    check("R3 sda never pulled", pull_rises, pr0);
    bus_stop();
  endtask

  task automatic t_extra_write();
    logic ack;
    logic [7:0] v;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h20, ack);
    check("R4 offset ack", ack, 1);
    send_byte(8'h99, ack);
    check("R5 data byte nack", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b0);
    check("R5 offset unchanged", v, edid_f(8'h20));
    bus_stop();
  endtask

  task automatic t_nack_end();
    logic ack, b;
    logic [7:0] v;
    int rd0;
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b0);
    check("R7 last byte", v, edid_f(8'h21));
    rd0 = rd_count;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    check("R7 sda released after nack", v, 8'hFF);
    check("R7 no fetch after nack", rd_count, rd0);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b0);
    check("R7 pointer past last byte", v, edid_f(8'h22));
    bus_stop();
  endtask

  task automatic t_restart();
    logic ack, b;
    logic [7:0] v;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start(); send_byte(8'hA1, ack);
    check("R9 restart mid address", ack, 1);
    // 0x23 -> 0x70; first three bits 0,1,1 then a released one bit
    for (int i = 2; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    check("R9 partial byte", v[2:0], 3'b011);
    bus_stop();
    wait_c(4);
    check("R9 released at stop", sda_pull, 0);
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(v, 1'b0);
    check("R9 aborted byte not counted", v, edid_f(8'h23));
    bus_stop();
    check("R10 pull only with scl low", r10_viol, 0);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    wait_c(5);
    rst_n = 1'b1;
    wait_c(5);
    t_reset();
    t_edid_seq();
    t_wrap();
    t_hdcp();
    t_bad_addr();
    t_extra_write();
    t_nack_end();
    t_restart();
    done = 1'b1;
    report();
  end
endmodule